// File: doc/BRIEF.md
# CAN Operating Mode Sequencer

This block owns the operating mode of a CAN protocol controller. Software places a 3-bit code on the requested-mode input. The mode actually in force is shown on a separate 3-bit status output. That status moves only when a change is safe. The block watches the sampled bit stream that an external bit-timing unit delivers, together with its strobe. It counts consecutive recessive samples to find an idle bus, and it holds back a move into configuration while a frame is being sent.

From the mode in force it drives the controls that the rest of the controller uses. These are the transmit, receive and acknowledge/error-signalling enables, the error-counter clear, hold and ignore controls, the internal loopback select, the ownership of the transmit and receive pins, and the unlock that permits writes to configuration registers. It also owns the transmit-request bit. A request raised right after entering a transmitting mode waits out a fresh idle period before it is handed on as a start pulse. A switch to disable during that wait cancels the request and raises a sticky abort flag. In disable mode a dominant sample raises a sticky wake flag. In the receive-everything mode an error pulse asks the message path to store the partial frame.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the status reads 100 (configuration), the recessive counter is empty, and the transmit-request, start, abort and wake outputs are all 0.
- R2: Request codes are 000 normal, 001 disable, 010 loopback, 011 listen-only, 100 configuration and 111 receive-everything. Codes 101 and 110 are ignored, and the status never shows them.
- R3: Each strobed recessive sample (bit_val=1) raises the idle counter by one, up to a ceiling of IDLE_BITS (11). A strobed dominant sample clears it. bus_idle is high while the counter sits at the ceiling. A valid request that differs from the status is taken on the first edge at which bus_idle is high. On that edge the status becomes the request and the counter restarts from 0.
- R4: A request for configuration is not taken on any edge where tx_busy is high.
- R5: In configuration mode transmit and receive are off, err_clr and cfg_unlock are 1, and both pins are released. cfg_unlock is 1 in no other mode.
- R6: In disable mode transmit, receive and acknowledge are off, err_hold is 1, and both pins are released. A strobed dominant sample sets wake_flag, which stays set until wake_clr.
- R7: In listen-only mode only receive is on, ack_en is 0, err_hold is 1, the receive pin is owned and the transmit pin is released.
- R8: In loopback mode loop_sel is 1, transmit, receive and acknowledge are on, and both pins are released.
- R9: In receive-everything mode err_ignore and err_hold are 1, only receive is on, and part_xfer follows rx_err in the same cycle. part_xfer is 0 in every other mode.
- R10: In normal mode transmit, receive and acknowledge are on, both pins are owned, and no error-counter control is active.
- R11: tx_req_set sets tx_pending. Entering normal or loopback opens an entry wait, which ends at the first edge where bus_idle is high. While tx_pending is set in normal or loopback with no wait open, the next edge raises tx_start for one cycle and clears tx_pending.
- R12: A disable request made while the entry wait is open is taken at once, even without bus idle. If tx_pending is set, it is cleared on that edge and tx_abort is set. tx_abort stays set until abort_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_mode | input | 3 | Requested mode code from software |
| bit_strobe | input | 1 | One-cycle strobe marking a sampled bus bit |
| bit_val | input | 1 | Sampled bit value, 1 = recessive |
| tx_busy | input | 1 | A frame transmission is in progress |
| tx_req_set | input | 1 | Software raises the transmit request |
| rx_err | input | 1 | Receive error pulse from the protocol engine |
| wake_clr | input | 1 | Clears wake_flag |
| abort_clr | input | 1 | Clears tx_abort |
| cur_mode | output | 3 | Mode in force |
| bus_idle | output | 1 | Idle threshold reached |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| ack_en | output | 1 | Acknowledge and error-frame driving enable |
| err_clr | output | 1 | Clear error counters |
| err_hold | output | 1 | Freeze error counters |
| err_ignore | output | 1 | Ignore detected errors |
| loop_sel | output | 1 | Route internal transmit into receive path |
| txpin_own | output | 1 | Controller owns the transmit pin |
| rxpin_own | output | 1 | Controller owns the receive pin |
| cfg_unlock | output | 1 | Configuration registers writable |
| part_xfer | output | 1 | Store partial frame on error |
| wake_flag | output | 1 | Sticky bus-activity wake flag |
| tx_pending | output | 1 | Transmit-request bit |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_abort | output | 1 | Sticky transmit-abort flag |

## Verification
A wrong idle count or a wrong acceptance rule shows on cur_mode and bus_idle. The status moves an edge early or late against the strobe stream, or it moves on a reserved code. The bench's model catches this on the first clock where the two differ. A wrong entry-wait state shows as a tx_start pulse that comes before the fresh idle run ends, or as a missing abort when disable cuts into the wait. Both are visible on tx_pending, tx_start and tx_abort within one cycle. A decode error shows at once in the control vector of the mode in force.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   typedef enum logic [2:0] {
      MD_NORMAL  = 3'b000,
      MD_DISABLE = 3'b001,
      MD_LOOP    = 3'b010,
      MD_LISTEN  = 3'b011,
      MD_CONFIG  = 3'b100,
      MD_RXALL   = 3'b111
   } mode_e;

   typedef struct packed {
      logic tx_en;
      logic rx_en;
      logic ack_en;
      logic err_clr;
      logic err_hold;
      logic err_ignore;
      logic loop_sel;
      logic txpin_own;
      logic rxpin_own;
      logic cfg_unlock;
   } ctrl_t;

   function automatic logic mode_valid(input logic [2:0] code);
      return (code != 3'b101) && (code != 3'b110);
   endfunction

   function automatic logic mode_can_tx(input logic [2:0] code);
      return (code == MD_NORMAL) || (code == MD_LOOP);
   endfunction

endpackage

// File: rtl/can_idle_cnt.sv
module can_idle_cnt #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic val,
   input  logic restart,
   output logic idle
);
   localparam int CW = $clog2(IDLE_BITS + 1);
   localparam logic [CW-1:0] TOP = CW'(IDLE_BITS);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (strobe) begin
         if (!val) begin
            cnt <= '0;
         end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign idle = (cnt == TOP);
endmodule

// File: rtl/can_mode_reg.sv
module can_mode_reg
   import can_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] req_mode,
   input  logic       idle,
   input  logic       tx_busy,
   input  logic       entry_wait,
   output mode_e      cur_mode,
   output logic       accept
);
   logic differs;
   logic gate_ok;
   logic early_off;

   assign differs   = mode_valid(req_mode) && (req_mode != cur_mode);
   assign early_off = (req_mode == MD_DISABLE) && entry_wait;
   assign gate_ok   = !((req_mode == MD_CONFIG) && tx_busy);
   assign accept    = differs && gate_ok && (idle || early_off);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_mode <= MD_CONFIG;
      end else if (accept) begin
         cur_mode <= mode_e'(req_mode);
      end
   end
endmodule

// File: rtl/can_mode_decode.sv
module can_mode_decode
   import can_mode_pkg::*;
(
   input  mode_e mode,
   output ctrl_t ctrl
);
   always_comb begin
      ctrl = '0;
      unique case (mode)
         MD_NORMAL: begin
            ctrl.tx_en     = 1'b1;
            ctrl.rx_en     = 1'b1;
            ctrl.ack_en    = 1'b1;
            ctrl.txpin_own = 1'b1;
            ctrl.rxpin_own = 1'b1;
         end
         MD_DISABLE: begin
            ctrl.err_hold = 1'b1;
         end
         MD_LOOP: begin
            ctrl.tx_en    = 1'b1;
            ctrl.rx_en    = 1'b1;
            ctrl.ack_en   = 1'b1;
            ctrl.loop_sel = 1'b1;
         end
         MD_LISTEN: begin
            ctrl.rx_en     = 1'b1;
            ctrl.err_hold  = 1'b1;
            ctrl.rxpin_own = 1'b1;
         end
         MD_RXALL: begin
            ctrl.rx_en      = 1'b1;
            ctrl.err_hold   = 1'b1;
            ctrl.err_ignore = 1'b1;
            ctrl.rxpin_own  = 1'b1;
         end
         default: begin
            ctrl.err_clr    = 1'b1;
            ctrl.cfg_unlock = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/can_tx_gate.sv
module can_tx_gate
   import can_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  mode_e      cur_mode,
   input  logic       accept,
   input  logic [2:0] target,
   input  logic       idle,
   input  logic       tx_req_set,
   input  logic       abort_clr,
   output logic       entry_wait,
   output logic       pending,
   output logic       start,
   output logic       abort
);
   logic go;
   logic cut;

   assign go  = pending && mode_can_tx(cur_mode) && !entry_wait;
   assign cut = accept && (target == MD_DISABLE) && entry_wait && pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_wait <= 1'b0;
      end else if (accept) begin
         entry_wait <= mode_can_tx(target);
      end else if (idle) begin
         entry_wait <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         start   <= 1'b0;
      end else begin
         start <= go;
         if (tx_req_set) begin
            pending <= 1'b1;
         end else if (go || cut) begin
            pending <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort <= 1'b0;
      end else if (cut) begin
         abort <= 1'b1;
      end else if (abort_clr) begin
         abort <= 1'b0;
      end
   end
endmodule

// File: rtl/can_wake_det.sv
module can_wake_det #(
   parameter int WAKE_MIN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic strobe,
   input  logic val,
   input  logic wake_clr,
   output logic wake_flag
);
   logic hit;

   generate
      if (WAKE_MIN == 1) begin : g_direct
         assign hit = armed && strobe && !val;
      end else begin : g_filter
         localparam int FW = $clog2(WAKE_MIN);
         localparam logic [FW-1:0] LAST = FW'(WAKE_MIN - 1);
         logic [FW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= '0;
            end else if (!armed) begin
               run <= '0;
            end else if (strobe) begin
               if (val) begin
                  run <= '0;
               end else if (run != LAST) begin
                  run <= run + 1'b1;
               end
            end
         end
         assign hit = armed && strobe && !val && (run == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_flag <= 1'b0;
      end else if (hit) begin
         wake_flag <= 1'b1;
      end else if (wake_clr) begin
         wake_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
   import can_mode_pkg::*;
#(
   parameter int IDLE_BITS = 11,
   parameter int WAKE_MIN  = 1,
   parameter int MODE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              bit_strobe,
   input  logic              bit_val,
   input  logic              tx_busy,
   input  logic              tx_req_set,
   input  logic              rx_err,
   input  logic              wake_clr,
   input  logic              abort_clr,
   output logic [MODE_W-1:0] cur_mode,
   output logic              bus_idle,
   output logic              tx_en,
   output logic              rx_en,
   output logic              ack_en,
   output logic              err_clr,
   output logic              err_hold,
   output logic              err_ignore,
   output logic              loop_sel,
   output logic              txpin_own,
   output logic              rxpin_own,
   output logic              cfg_unlock,
   output logic              part_xfer,
   output logic              wake_flag,
   output logic              tx_pending,
   output logic              tx_start,
   output logic              tx_abort
);
   generate
      if (MODE_W != 3) begin : g_bad_w
         $error("MODE_W must be 3");
      end
      if (IDLE_BITS < 2) begin : g_bad_idle
         $error("IDLE_BITS must be at least 2");
      end
      if (WAKE_MIN < 1) begin : g_bad_wake
         $error("WAKE_MIN must be at least 1");
      end
   endgenerate

   mode_e mode_q;
   logic  accept;
   logic  entry_wait;
   ctrl_t ctrl;

   can_idle_cnt #(.IDLE_BITS(IDLE_BITS)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (bit_strobe),
      .val     (bit_val),
      .restart (accept),
      .idle    (bus_idle)
   );

   can_mode_reg u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_mode   (req_mode),
      .idle       (bus_idle),
      .tx_busy    (tx_busy),
      .entry_wait (entry_wait),
      .cur_mode   (mode_q),
      .accept     (accept)
   );

   can_mode_decode u_dec (
      .mode (mode_q),
      .ctrl (ctrl)
   );

   can_tx_gate u_txg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_mode   (mode_q),
      .accept     (accept),
      .target     (req_mode),
      .idle       (bus_idle),
      .tx_req_set (tx_req_set),
      .abort_clr  (abort_clr),
      .entry_wait (entry_wait),
      .pending    (tx_pending),
      .start      (tx_start),
      .abort      (tx_abort)
   );

   can_wake_det #(.WAKE_MIN(WAKE_MIN)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (mode_q == MD_DISABLE),
      .strobe    (bit_strobe),
      .val       (bit_val),
      .wake_clr  (wake_clr),
      .wake_flag (wake_flag)
   );

   assign cur_mode   = mode_q;
   assign tx_en      = ctrl.tx_en;
   assign rx_en      = ctrl.rx_en;
   assign ack_en     = ctrl.ack_en;
   assign err_clr    = ctrl.err_clr;
   assign err_hold   = ctrl.err_hold;
   assign err_ignore = ctrl.err_ignore;
   assign loop_sel   = ctrl.loop_sel;
   assign txpin_own  = ctrl.txpin_own;
   assign rxpin_own  = ctrl.rxpin_own;
   assign cfg_unlock = ctrl.cfg_unlock;
   assign part_xfer  = ctrl.err_ignore & rx_err;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] req_mode,
   input logic       tx_busy,
   input logic [2:0] cur_mode,
   input logic       tx_en,
   input logic       rx_en,
   input logic       cfg_unlock,
   input logic       tx_start,
   input logic       tx_pending,
   input logic       tx_abort
);
   p_status_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_mode) |-> (cur_mode == $past(req_mode)));

   p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode != 3'b101) && (cur_mode != 3'b110));

   p_cfg_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_mode == 3'b100) && ($past(cur_mode) != 3'b100)) |-> !$past(tx_busy));

   p_unlock_cfg_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_unlock |-> (cur_mode == 3'b100));

   p_disable_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'b001) |-> (!tx_en && !rx_en));

   p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);

   p_start_takes_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_start) |-> $past(tx_pending));

   p_abort_drops_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_abort) |-> (!tx_pending && (cur_mode == 3'b001)));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_mode   (req_mode),
   .tx_busy    (tx_busy),
   .cur_mode   (cur_mode),
   .tx_en      (tx_en),
   .rx_en      (rx_en),
   .cfg_unlock (cfg_unlock),
   .tx_start   (tx_start),
   .tx_pending (tx_pending),
   .tx_abort   (tx_abort)
);

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] req_mode = 3'b100;
   logic bit_strobe = 1'b0, bit_val = 1'b1, tx_busy = 1'b0, tx_req_set = 1'b0;
   logic rx_err = 1'b0, wake_clr = 1'b0, abort_clr = 1'b0;
   logic [2:0] cur_mode;
   logic bus_idle, tx_en, rx_en, ack_en, err_clr, err_hold, err_ignore, loop_sel;
   logic txpin_own, rxpin_own, cfg_unlock, part_xfer, wake_flag, tx_pending, tx_start, tx_abort;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int m_mode = 4, m_cnt = 0;
   bit m_wait = 0, m_pend = 0, m_start = 0, m_abort = 0, m_wake = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_mode_seq u_can_mode_seq (.*);

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit [9:0] ctrl_of(input int m);
      // tx rx ack clr hold ign loop txp rxp unl
      case (m)
         0: return 10'b1110000110;
         1: return 10'b0000100000;
         2: return 10'b1110001000;
         3: return 10'b0100100010;
         7: return 10'b0100110010;
         default: return 10'b0001000001;
      endcase
   endfunction

   function automatic string tag_of(input int m);
      case (m)
         0: return "R10";
         1: return "R6";
         2: return "R8";
         3: return "R7";
         7: return "R9";
         default: return "R5";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         bit idle, acc, go, cut, valid, cap_old;
         idle    = (m_cnt == 11);
         valid   = (req_mode != 3'b101) && (req_mode != 3'b110);
         acc     = valid && (int'(req_mode) != m_mode) &&
                   (idle || (req_mode == 3'b001 && m_wait)) &&
                   !(req_mode == 3'b100 && tx_busy);
         cap_old = (m_mode == 0) || (m_mode == 2);
         go      = m_pend && cap_old && !m_wait;
         cut     = acc && (req_mode == 3'b001) && m_wait && m_pend;
         if (m_mode == 1 && bit_strobe && !bit_val) m_wake = 1;
         else if (wake_clr) m_wake = 0;
         if (acc) m_cnt = 0;
         else if (bit_strobe) m_cnt = bit_val ? ((m_cnt < 11) ? m_cnt + 1 : 11) : 0;
         if (acc) m_wait = (req_mode == 3'b000) || (req_mode == 3'b010);
         else if (idle) m_wait = 0;
         m_start = go;
         if (tx_req_set) m_pend = 1;
         else if (go || cut) m_pend = 0;
         if (cut) m_abort = 1;
         else if (abort_clr) m_abort = 0;
         if (acc) m_mode = int'(req_mode);
         // compare
         check("R3 cur_mode", int'(cur_mode), m_mode);
         check("R3 bus_idle", int'(bus_idle), int'(m_cnt == 11));
         check({tag_of(m_mode), " ctrl"},
               int'({tx_en, rx_en, ack_en, err_clr, err_hold, err_ignore,
                     loop_sel, txpin_own, rxpin_own, cfg_unlock}),
               int'(ctrl_of(m_mode)));
         check("R9 part_xfer", int'(part_xfer), int'(rx_err && m_mode == 7));
         check("R6 wake_flag", int'(wake_flag), int'(m_wake));
         check("R11 tx_pending", int'(tx_pending), int'(m_pend));
         check("R11 tx_start", int'(tx_start), int'(m_start));
         check("R12 tx_abort", int'(tx_abort), int'(m_abort));
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         bit_strobe = 1'b0; tx_req_set = 1'b0; rx_err = 1'b0;
         wake_clr = 1'b0; abort_clr = 1'b0;
      end
   endtask

   task automatic bits(input int n, input logic v);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         tx_req_set = 1'b0; rx_err = 1'b0; wake_clr = 1'b0; abort_clr = 1'b0;
         bit_strobe = 1'b1; bit_val = v;
      end
      @(negedge clk); #1;
      bit_strobe = 1'b0; bit_val = 1'b1;
   endtask

   task automatic pulse_req();
      @(negedge clk); #1; tx_req_set = 1'b1;
      @(negedge clk); #1; tx_req_set = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      step(3);
      // R1: reset state
      check("R1 cur_mode", int'(cur_mode), 4);
      check("R1 cfg_unlock", int'(cfg_unlock), 1);
      check("R1 flags", int'({tx_pending, tx_start, tx_abort, wake_flag, bus_idle}), 0);
      @(negedge clk); #1; rst_n = 1'b1;
      // R3: dominant sample restarts the count; go to normal
      req_mode = 3'b000;
      bits(5, 1'b1);
      check("R3 no early change", int'(cur_mode), 4);
      bits(1, 1'b0);
      bits(10, 1'b1);
      check("R3 ten bits short", int'(cur_mode), 4);
      bits(1, 1'b1);
      step(1);
      check("R3 entered normal", int'(cur_mode), 0);
      // R2: reserved codes ignored
      req_mode = 3'b101;
      bits(12, 1'b1);
      req_mode = 3'b110;
      bits(3, 1'b1);
      check("R2 reserved ignored", int'(cur_mode), 0);
      // R11: wait already over, request starts
      req_mode = 3'b000;
      pulse_req();
      step(3);
      // R11: request right after entry waits for idle run
      req_mode = 3'b011;
      step(2);
      check("R7 listen entered", int'(cur_mode), 3);
      bits(12, 1'b1);
      req_mode = 3'b000;
      step(2);
      pulse_req();
      step(3);
      check("R11 held during wait", int'(tx_pending), 1);
      bits(11, 1'b1);
      step(3);
      check("R11 released after idle", int'(tx_pending), 0);
      // R12: disable during entry wait aborts
      req_mode = 3'b011;
      step(2);
      bits(12, 1'b1);
      req_mode = 3'b000;
      step(2);
      pulse_req();
      bits(3, 1'b1);
      req_mode = 3'b001;
      step(2);
      check("R12 disable taken", int'(cur_mode), 1);
      check("R12 abort set", int'(tx_abort), 1);
      @(negedge clk); #1; abort_clr = 1'b1;
      step(2);
      // R6: wake on dominant in disable
      bits(1, 1'b0);
      check("R6 wake set", int'(wake_flag), 1);
      @(negedge clk); #1; wake_clr = 1'b1;
      step(2);
      // R4: configuration held off by tx_busy
      tx_busy = 1'b1;
      req_mode = 3'b100;
      bits(14, 1'b1);
      check("R4 config blocked", int'(cur_mode), 1);
      tx_busy = 1'b0;
      step(2);
      check("R4 config after idle", int'(cur_mode), 4);
      // R8: loopback
      req_mode = 3'b010;
      bits(12, 1'b1);
      step(1);
      check("R8 loopback", int'(loop_sel), 1);
      // R9: receive everything
      req_mode = 3'b111;
      bits(12, 1'b1);
      step(1);
      @(negedge clk); #1; rx_err = 1'b1;
      step(2);
      check("R9 mode", int'(cur_mode), 7);
      step(4);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule